// File: doc/BRIEF.md
# Rejection-Sampling NTT Coefficient Generator

This block produces one polynomial of 256 coefficients, each below the modulus q = 3329, from a byte stream squeezed out of an external extendable-output hash engine. A caller places a 256-bit public seed and two one-byte matrix indices on a request port. The block then streams the 34-byte absorb message to the hash engine over a valid/ready byte port. Finally it reads squeezed bytes back over a second valid/ready byte port. The hash permutation is outside this block.

The block reads squeezed bytes in groups of three. Each group yields two 12-bit candidates. Candidates at or above q are discarded, and surviving ones leave one per handshake on a coefficient port that carries a last flag. When both candidates of a group survive while the consumer is stalling, the second one waits in a one-entry holding register and byte intake pauses. After the last coefficient the block clears its counters, its partial group and its holding register, so the next request starts clean. A caller that builds a rank-2 matrix issues four requests, with (row, column) equal to (0,0), (0,1), (1,0) and (1,1) in that order.

Top module: `xof_rej_sampler`

## Requirements
- R1: The absorb message has 34 bytes in this order: bytes 0 to 31 are the seed, with message byte k taken from `req_seed[8k+7:8k]`; byte 32 is the column index `req_col`; byte 33 is the row index `req_row`. `msg_last` is high on byte 33 only.
- R2: Each accepted request yields exactly 256 coefficient handshakes. `coef_last` is high on the 256th and on no other.
- R3: Every emitted coefficient is 12 bits wide and lies in 0..3328.
- R4: For squeezed bytes b0, b1, b2 taken in arrival order, the block forms d1 = b0 + 256*(b1 mod 16) and d2 = floor(b1/16) + 16*b2. A candidate of 3329 or more is discarded. Accepted candidates are emitted in stream order, with d1 before d2.
- R5: While `coef_valid` is high and `coef_ready` is low, `coef_data` and `coef_last` hold their values.
- R6: `req_ready` is high only when the block is idle. A request is taken in one handshake, and `req_ready` stays low from then until the 256th coefficient has been accepted.
- R7: When d1 of a group is the 256th accepted candidate, that group's d2 is dropped. Once 256 candidates have been produced, no further squeezed byte is taken, so a request consumes exactly three times the number of groups it needed.
- R8: When the consumer stalls, at most one coefficient waits beyond the output register. If both candidates of a group survive, the second is held and `xof_ready` stays low until it drains. If only one survives, the third byte of the next group is not taken while the output register is full. No candidate is lost.
- R9: After the last coefficient is accepted, the block returns to idle in the next cycle with `coef_valid` low, and the next request parses its squeezed stream from a fresh three-byte group with no leftover candidate.
- R10: After reset, and while the absorb message is being sent, `xof_ready` is low. After reset `req_ready` is high and `msg_valid` and `coef_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_seed | input | 256 | Public seed, message byte k in bits 8k+7:8k |
| req_row | input | 8 | Row index, sent as message byte 33 |
| req_col | input | 8 | Column index, sent as message byte 32 |
| msg_valid | output | 1 | Absorb message byte present |
| msg_ready | input | 1 | Hash engine takes the message byte |
| msg_byte | output | 8 | Absorb message byte |
| msg_last | output | 1 | Final message byte |
| xof_valid | input | 1 | Squeezed byte present |
| xof_ready | output | 1 | Block takes the squeezed byte |
| xof_byte | input | 8 | Squeezed byte |
| coef_valid | output | 1 | Coefficient present |
| coef_ready | input | 1 | Consumer takes the coefficient |
| coef_data | output | 12 | Coefficient, 0..3328 |
| coef_last | output | 1 | 256th coefficient of the polynomial |

## Verification
Message bytes come combinationally from the registered byte index. `msg_byte` is therefore due in the same cycle as `msg_valid`, and the bench compares it at each handshake. A surviving d1, or a lone surviving d2, appears on `coef_valid` one clock after the third byte of its group is taken. A held d2 follows one clock after the first coefficient's handshake. The bench does not predict cycle numbers for coefficients: it drives inputs at the falling edge, samples 1 ns later, and compares each coefficient at its own handshake against a list the bench computes from the squeezed bytes. Byte counts under a stall, the idle state one clock after the last beat, and the total bytes consumed are checked at fixed points relative to those handshakes.

// File: rtl/xsmp_pkg.sv
package xsmp_pkg;

    localparam int COEFF_W = 12;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ABSORB  = 2'd1,
        ST_SQUEEZE = 2'd2
    } xsmp_state_e;

endpackage

// File: rtl/xsmp_msg_former.sv
module xsmp_msg_former #(
    parameter int SEED_BYTES = 32,
    parameter int MIDX_W     = 6
) (
    input  logic [SEED_BYTES*8-1:0] seed,
    input  logic [7:0]              row,
    input  logic [7:0]              col,
    input  logic [MIDX_W-1:0]       midx,
    output logic [7:0]              byte_o,
    output logic                    last_o
);
    localparam int MSG_LEN = SEED_BYTES + 2;

    // Seed bytes first, then the column index, then the row index.
    always_comb begin
        byte_o = row;
        for (int k = 0; k < SEED_BYTES; k++) begin
            if (int'(midx) == k) byte_o = seed[k*8 +: 8];
        end
        if (int'(midx) == SEED_BYTES) byte_o = col;
        last_o = (int'(midx) == MSG_LEN - 1);
    end
endmodule

// File: rtl/xsmp_group_split.sv
module xsmp_group_split #(
    parameter int Q = 3329
) (
    input  logic [7:0]                    b0,
    input  logic [7:0]                    b1,
    input  logic [7:0]                    b2,
    output logic [xsmp_pkg::COEFF_W-1:0]  d1,
    output logic [xsmp_pkg::COEFF_W-1:0]  d2,
    output logic                          ok1,
    output logic                          ok2
);
    localparam logic [xsmp_pkg::COEFF_W-1:0] Q_C = xsmp_pkg::COEFF_W'(Q);

    always_comb begin
        d1  = {b1[3:0], b0};
        d2  = {b2, b1[7:4]};
        ok1 = (d1 < Q_C);
        ok2 = (d2 < Q_C);
    end
endmodule

// File: rtl/xof_rej_sampler.sv
module xof_rej_sampler #(
    parameter int SEED_BYTES = 32,
    parameter int Q          = 3329,
    parameter int N_COEFF    = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [SEED_BYTES*8-1:0]       req_seed,
    input  logic [7:0]                    req_row,
    input  logic [7:0]                    req_col,
    output logic                          msg_valid,
    input  logic                          msg_ready,
    output logic [7:0]                    msg_byte,
    output logic                          msg_last,
    input  logic                          xof_valid,
    output logic                          xof_ready,
    input  logic [7:0]                    xof_byte,
    output logic                          coef_valid,
    input  logic                          coef_ready,
    output logic [xsmp_pkg::COEFF_W-1:0]  coef_data,
    output logic                          coef_last
);
    import xsmp_pkg::*;

    localparam int MSG_LEN = SEED_BYTES + 2;
    localparam int MIDX_W  = $clog2(MSG_LEN);
    localparam int CNT_W   = $clog2(N_COEFF + 1);
    localparam logic [CNT_W-1:0] N_C    = CNT_W'(N_COEFF);
    localparam logic [CNT_W-1:0] N_LAST = CNT_W'(N_COEFF - 1);

    typedef struct packed {
        xsmp_state_e             st;
        logic [SEED_BYTES*8-1:0] seed;
        logic [7:0]              row;
        logic [7:0]              col;
        logic [MIDX_W-1:0]       midx;
        logic [1:0]              gpos;
        logic [7:0]              b0;
        logic [7:0]              b1;
        logic [CNT_W-1:0]        made;
        logic                    ov;
        logic [COEFF_W-1:0]      oc;
        logic                    ol;
        logic                    hv;
        logic [COEFF_W-1:0]      hc;
        logic                    hl;
    } xsmp_regs_t;

    xsmp_regs_t r_q, r_d;

    logic [COEFF_W-1:0] cand1, cand2;
    logic               keep1, keep2;
    logic               take2;
    logic               slot_free, out_fire, in_fire;

    xsmp_msg_former #(
        .SEED_BYTES (SEED_BYTES),
        .MIDX_W     (MIDX_W)
    ) i_msg (
        .seed   (r_q.seed),
        .row    (r_q.row),
        .col    (r_q.col),
        .midx   (r_q.midx),
        .byte_o (msg_byte),
        .last_o (msg_last)
    );

    xsmp_group_split #(
        .Q (Q)
    ) i_split (
        .b0  (r_q.b0),
        .b1  (r_q.b1),
        .b2  (xof_byte),
        .d1  (cand1),
        .d2  (cand2),
        .ok1 (keep1),
        .ok2 (keep2)
    );

    always_comb begin
        r_d       = r_q;
        req_ready = (r_q.st == ST_IDLE);
        msg_valid = (r_q.st == ST_ABSORB);
        out_fire  = r_q.ov && coef_ready;
        slot_free = !r_q.ov || coef_ready;
        // Byte intake pauses while a candidate is held, once the polynomial
        // is complete, and on a group's third byte if the output slot is busy.
        xof_ready = (r_q.st == ST_SQUEEZE) && !r_q.hv && (r_q.made < N_C)
                    && ((r_q.gpos != 2'd2) || slot_free);
        in_fire   = xof_valid && xof_ready;
        take2     = keep2 && ((r_q.made + CNT_W'(keep1)) < N_C);

        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st   = ST_ABSORB;
                    r_d.seed = req_seed;
                    r_d.row  = req_row;
                    r_d.col  = req_col;
                    r_d.midx = '0;
                end
            end
            ST_ABSORB: begin
                if (msg_ready) begin
                    if (msg_last) begin
                        r_d.st   = ST_SQUEEZE;
                        r_d.midx = '0;
                    end else begin
                        r_d.midx = r_q.midx + MIDX_W'(1);
                    end
                end
            end
            default: ;
        endcase

        // Output register and one-entry holding register.
        if (out_fire) r_d.ov = 1'b0;
        if (slot_free && r_q.hv) begin
            r_d.ov = 1'b1;
            r_d.oc = r_q.hc;
            r_d.ol = r_q.hl;
            r_d.hv = 1'b0;
        end

        if (in_fire) begin
            unique case (r_q.gpos)
                2'd0: begin
                    r_d.b0   = xof_byte;
                    r_d.gpos = 2'd1;
                end
                2'd1: begin
                    r_d.b1   = xof_byte;
                    r_d.gpos = 2'd2;
                end
                default: begin
                    r_d.gpos = 2'd0;
                    if (keep1) begin
                        r_d.ov = 1'b1;
                        r_d.oc = cand1;
                        r_d.ol = (r_q.made == N_LAST);
                        if (take2) begin
                            r_d.hv = 1'b1;
                            r_d.hc = cand2;
                            r_d.hl = ((r_q.made + CNT_W'(1)) == N_LAST);
                        end
                    end else if (take2) begin
                        r_d.ov = 1'b1;
                        r_d.oc = cand2;
                        r_d.ol = (r_q.made == N_LAST);
                    end
                    r_d.made = r_q.made + CNT_W'(keep1) + CNT_W'(take2);
                end
            endcase
        end

        // Flush on the final beat so nothing carries into the next request.
        if (out_fire && r_q.ol) begin
            r_d.st   = ST_IDLE;
            r_d.made = '0;
            r_d.gpos = 2'd0;
            r_d.hv   = 1'b0;
            r_d.ov   = 1'b0;
            r_d.ol   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign coef_valid = r_q.ov;
    assign coef_data  = r_q.oc;
    assign coef_last  = r_q.ol;
endmodule

// File: rtl/xsmp_checker.sv
module xsmp_checker #(
    parameter int SEED_BYTES = 32,
    parameter int Q          = 3329,
    parameter int N_COEFF    = 256
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic                          req_ready,
    input logic                          msg_valid,
    input logic                          msg_ready,
    input logic                          msg_last,
    input logic                          xof_ready,
    input logic                          coef_valid,
    input logic                          coef_ready,
    input logic [xsmp_pkg::COEFF_W-1:0]  coef_data,
    input logic                          coef_last
);
    localparam int MSG_LEN = SEED_BYTES + 2;
    localparam int CNT_W   = $clog2(N_COEFF + 1);
    localparam int MC_W    = $clog2(MSG_LEN + 1);
    localparam logic [xsmp_pkg::COEFF_W-1:0] Q_C = xsmp_pkg::COEFF_W'(Q);

    logic [CNT_W-1:0] beats_q;
    logic [MC_W-1:0]  mbytes_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats_q  <= '0;
            mbytes_q <= '0;
        end else begin
            if (coef_valid && coef_ready)
                beats_q <= coef_last ? '0 : beats_q + CNT_W'(1);
            if (msg_valid && msg_ready)
                mbytes_q <= msg_last ? '0 : mbytes_q + MC_W'(1);
        end
    end

    a_r1_msg_last_position: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_last == (int'(mbytes_q) == MSG_LEN - 1)));

    a_r2_last_on_final_beat: assert property (@(posedge clk) disable iff (!rst_n)
        coef_valid |-> (coef_last == (int'(beats_q) == N_COEFF - 1)));

    a_r3_coeff_below_q: assert property (@(posedge clk) disable iff (!rst_n)
        coef_valid |-> (coef_data < Q_C));

    a_r5_stable_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_valid && !coef_ready) |=> (coef_valid && $stable(coef_data) && $stable(coef_last)));

    a_r6_one_request_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r9_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_valid && coef_ready && coef_last) |=> (req_ready && !coef_valid && !xof_ready));

    a_r10_no_intake_while_absorbing: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> !xof_ready);
endmodule

bind xof_rej_sampler xsmp_checker #(
    .SEED_BYTES (SEED_BYTES),
    .Q          (Q),
    .N_COEFF    (N_COEFF)
) i_xsmp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_last   (msg_last),
    .xof_ready  (xof_ready),
    .coef_valid (coef_valid),
    .coef_ready (coef_ready),
    .coef_data  (coef_data),
    .coef_last  (coef_last)
);

// File: tb/test_xof_rej_sampler.sv
`timescale 1ns/1ps
module test_xof_rej_sampler;
    localparam int Q  = 3329;
    localparam int N  = 256;
    localparam int SB = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          req_valid, req_ready;
    logic [SB*8-1:0] req_seed;
    logic [7:0]    req_row, req_col;
    logic          msg_valid, msg_ready, msg_last;
    logic [7:0]    msg_byte;
    logic          xof_valid, xof_ready;
    logic [7:0]    xof_byte;
    logic          coef_valid, coef_ready, coef_last;
    logic [11:0]   coef_data;

    xof_rej_sampler i_xof_rej_sampler (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_seed(req_seed),
        .req_row(req_row), .req_col(req_col),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_byte(msg_byte), .msg_last(msg_last),
        .xof_valid(xof_valid), .xof_ready(xof_ready), .xof_byte(xof_byte),
        .coef_valid(coef_valid), .coef_ready(coef_ready), .coef_data(coef_data), .coef_last(coef_last)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int exp_c [N];
    int exp_bytes, stall_bytes;
    int dut_first, dut_bytes;
    logic [15:0] lf = 16'hACE1;

    // Request table: {row, col, stream key, out-ready mode, in-valid mode}.
    // The rank-2 matrix order (0,0),(0,1),(1,0),(1,1) is walked first.
    localparam logic [31:0] VEC [6] = '{
        {8'd0, 8'd0, 8'd5,  4'd0, 4'd0},
        {8'd0, 8'd1, 8'd6,  4'd1, 4'd1},
        {8'd1, 8'd0, 8'd0,  4'd2, 4'd0},
        {8'd1, 8'd1, 8'd9,  4'd1, 4'd2},
        {8'd0, 8'd0, 8'd12, 4'd2, 4'd1},
        {8'd2, 8'd3, 8'd7,  4'd0, 4'd2}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    function automatic logic [7:0] gen_byte(input int key, input int k);
        int x;
        if (key == 0) return (k < 2) ? 8'hFF : 8'h00;
        if ((key % 2 == 1) && (k % 15) < 3) return 8'hFF;
        x = key * 131 + k * 197 + (k / 7) * 53 + key * k * 11;
        x = x ^ (x >> 5);
        return x[7:0];
    endfunction

    function automatic logic [SB*8-1:0] make_seed(input int key);
        logic [SB*8-1:0] s;
        for (int k = 0; k < SB; k++) s[k*8 +: 8] = 8'(key * 29 + k * 7 + 1);
        return s;
    endfunction

    // Reference parse built from R4/R7/R8.
    task automatic build_expected(input int key);
        int made, g, got, b0, b1, b2, d1, d2;
        made = 0; g = 0; stall_bytes = 0;
        while (made < N) begin
            b0 = gen_byte(key, 3*g); b1 = gen_byte(key, 3*g+1); b2 = gen_byte(key, 3*g+2);
            d1 = b0 + 256 * (b1 % 16);
            d2 = b1 / 16 + 16 * b2;
            got = 0;
            if (d1 < Q) begin exp_c[made] = d1; made++; got++; end
            if (d2 < Q && made < N) begin exp_c[made] = d2; made++; got++; end
            if (got > 0 && stall_bytes == 0) stall_bytes = (got == 2) ? 3*(g+1) : 3*(g+1) + 2;
            g++;
        end
        exp_bytes = 3 * g;
    endtask

    task automatic run_req(input int row, input int col, input int key,
                           input int omode, input int imode, input int stall);
        int mcnt, bytes, oidx, cyc, sq_cyc, eb;
        bit msg_done, done, stalled, ipol, opol;
        logic [SB*8-1:0] sd;
        mcnt = 0; bytes = 0; oidx = 0; cyc = 0; sq_cyc = 0;
        msg_done = 0; done = 0; dut_first = -1;
        sd = make_seed(key);
        build_expected(key);
        @(negedge clk);
        req_valid = 1'b1; req_seed = sd; req_row = 8'(row); req_col = 8'(col);
        #1;
        chk(req_ready == 1'b1, "R6 request taken when idle", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (msg_done) sq_cyc++;
            stalled = msg_done && (sq_cyc <= stall);
            opol = (omode == 0) ? 1'b1 : (omode == 1) ? (cyc % 3 == 0) : lf[0];
            ipol = (imode == 0) ? 1'b1 : (imode == 1) ? (cyc % 4 != 2) : (cyc % 2 == 0);
            coef_ready = stalled ? 1'b0 : opol;
            msg_ready  = ipol;
            xof_valid  = msg_done && (stalled || ipol);
            xof_byte   = gen_byte(key, bytes);
            #1;
            if (cyc == 3) chk(xof_ready == 1'b0, "R10 no byte intake while absorbing", int'(xof_ready), 0);
            if (cyc == 40) chk(req_ready == 1'b0, "R6 busy blocks new request", int'(req_ready), 0);
            if (stall > 0 && msg_done && sq_cyc == stall) begin
                chk(bytes == stall_bytes, "R8 bytes taken under stall", bytes, stall_bytes);
                chk(xof_ready == 1'b0, "R8 intake paused under stall", int'(xof_ready), 0);
                chk(coef_valid && coef_data == 12'(exp_c[0]), "R5 first coefficient held", int'(coef_data), exp_c[0]);
            end
            if (msg_valid && msg_ready && mcnt < SB + 2) begin
                eb = (mcnt < SB) ? int'(sd[8*mcnt +: 8]) : (mcnt == SB) ? col : row;
                chk(int'(msg_byte) == eb, "R1 message byte", int'(msg_byte), eb);
                chk(msg_last == (mcnt == SB + 1), "R1 message last flag", int'(msg_last), int'(mcnt == SB + 1));
                mcnt++;
                if (msg_last) msg_done = 1;
            end
            if (xof_valid && xof_ready) bytes++;
            if (coef_valid && coef_ready) begin
                if (oidx == 0) dut_first = int'(coef_data);
                if (oidx < N) begin
                    chk(int'(coef_data) == exp_c[oidx], "R4 coefficient value", int'(coef_data), exp_c[oidx]);
                    chk(int'(coef_data) < Q, "R3 coefficient below q", int'(coef_data), Q - 1);
                end
                chk(coef_last == (oidx == N - 1), "R2 last flag position", int'(coef_last), int'(oidx == N - 1));
                oidx++;
                if (coef_last || oidx > N) done = 1;
            end
        end
        chk(oidx == N, "R2 coefficient count", oidx, N);
        dut_bytes = bytes;
        @(negedge clk);
        coef_ready = 1'b0; msg_ready = 1'b0; xof_valid = 1'b0;
        #1;
        chk(req_ready == 1'b1, "R9 idle after last", int'(req_ready), 1);
        chk(coef_valid == 1'b0, "R9 no leftover coefficient", int'(coef_valid), 0);
        chk(bytes == exp_bytes, "R7 squeezed bytes consumed", bytes, exp_bytes);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_seed = '0; req_row = '0; req_col = '0;
        msg_ready = 1'b0; xof_valid = 1'b0; xof_byte = '0; coef_ready = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(req_ready == 1'b1, "R10 reset req_ready", int'(req_ready), 1);
        chk(msg_valid == 1'b0, "R10 reset msg_valid", int'(msg_valid), 0);
        chk(xof_ready == 1'b0, "R10 reset xof_ready", int'(xof_ready), 0);
        chk(coef_valid == 1'b0, "R10 reset coef_valid", int'(coef_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < 6; v++)
            run_req(int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]),
                    int'(VEC[v][7:4]), int'(VEC[v][3:0]), 0);

        // Hold buffer and intake pause under a long output stall (R8, R5).
        run_req(0, 1, 21, 0, 0, 60);
        run_req(1, 0, 4, 1, 0, 50);

        // Group FF FF 00 then zeros: d1 rejected, d2 = 15, and the 256th
        // coefficient is a d1, so its d2 is dropped after 129 groups (R4, R7).
        run_req(1, 1, 0, 0, 0, 0);
        chk(dut_first == 15, "R4 d2 from upper nibble and third byte", dut_first, 15);
        chk(dut_bytes == 387, "R7 d2 dropped, no extra bytes", dut_bytes, 387);
        // The dropped zero must not appear as the next request's first value (R9).
        run_req(0, 0, 9, 0, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule